// File: doc/BRIEF.md
# ADC Dual-Stream Frame Serializer

This block takes all sixteen 12-bit samples of one ADC conversion in a single clock cycle and sends them out on two serial lanes. Each lane carries half of the channels. Every conversion produces one frame per lane: a 4-bit header, then eight samples of 96 payload bits in total. The frame is 100 bits long. At a 2 MSPS conversion rate and a 200 Mb/s lane rate, one frame takes exactly one conversion period.

The block runs in the system clock domain. A bit-enable input marks each serial bit slot. The convert strobe captures the sample bus together with the header value. A frame-start output marks the first header bit so that a downstream encoder can find the frame boundaries.

A strobe that arrives while a frame is still being sent is dropped, and a saturating counter records it. A strobe that arrives in the cycle that sends the last bit is accepted, so strobes at exactly the frame period give gapless frames.

Top module: `adc_frame_serializer`

## Requirements
- R1: While reset is low, and right after it is released, both serial outputs and the frame-start output are 0 and the overrun count is 0.
- R2: A frame is 100 bit slots long. The frame-start output is 1 for exactly the first bit slot of each frame and 0 in every other slot.
- R3: Each frame begins with the 4 header bits captured with the strobe, most significant bit first. Both lanes carry the same header.
- R4: Lane 0 carries channels 0 to 7 and lane 1 carries channels 8 to 15, each in ascending channel order and each sample most significant bit first. Channel c sits at bits [12c+11:12c] of the sample bus.
- R5: The first header bit appears on the first bit-enable cycle after the capture cycle. A bit-enable in the capture cycle itself does not send a bit of the new frame.
- R6: The outputs change only on clock edges at which bit-enable is 1, and hold their value otherwise.
- R7: A convert strobe during a frame, other than in the cycle that sends the last bit, is ignored and raises the overrun count by one. The count saturates at its all-ones value.
- R8: A convert strobe in the cycle that sends the last bit of a frame is accepted, so the next frame follows with no idle bit slot.
- R9: In bit slots with no frame in progress, both serial outputs and the frame-start output are 0.
- R10: The frame carries the sample bus and header as they were in the capture cycle. Later changes to those inputs have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samples_i | input | 192 | All channel samples, channel c at bits [12c+11:12c] |
| convert_i | input | 1 | Conversion strobe, captures samples and header |
| bit_en_i | input | 1 | Serial bit-slot enable |
| header_i | input | 4 | Header value placed at the start of each frame |
| ser_o | output | 2 | Serial bit per lane, bit s for lane s |
| frame_start_o | output | 1 | High during the first bit slot of each frame |
| overrun_cnt_o | output | 8 | Saturating count of dropped strobes |

## Verification
The bench builds the block with its default parameters: sixteen channels, 12-bit samples, two lanes, a 4-bit header and an 8-bit overrun counter. The 8-bit counter makes saturation reachable in a few hundred cycles by holding the strobe high while bit-enable is low. The 100-bit frame keeps the gapless back-to-back case and sparse bit-enable patterns inside a short run. A queue model of each lane's bits is compared with the outputs on every clock.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

   function automatic int unsigned lane_frame_bits(input int unsigned hdr_w,
                                                   input int unsigned ch_per_lane,
                                                   input int unsigned sample_w);
      return hdr_w + ch_per_lane * sample_w;
   endfunction

   function automatic int unsigned count_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/adc_ser_ctrl.sv
module adc_ser_ctrl #(
   parameter int unsigned FRAME_LEN = 100,
   parameter int unsigned OVR_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             convert_i,
   input  logic             bit_en_i,
   output logic             load_o,
   output logic             shift_o,
   output logic             first_o,
   output logic             busy_o,
   output logic             last_o,
   output logic [OVR_W-1:0] overrun_cnt_o
);
   localparam int unsigned CNT_W = adc_ser_pkg::count_width(FRAME_LEN);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
   localparam logic [OVR_W-1:0] OVR_MAX  = {OVR_W{1'b1}};

   logic [CNT_W-1:0] bit_idx;
   logic             busy;
   logic [OVR_W-1:0] ovr_cnt;

   assign shift_o = bit_en_i & busy;
   assign last_o  = shift_o & (bit_idx == LAST_IDX);
   assign load_o  = convert_i & (~busy | last_o);
   assign first_o = shift_o & (bit_idx == '0);
   assign busy_o  = busy;
   assign overrun_cnt_o = ovr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bit_idx <= '0;
      end else if (load_o) begin
         busy    <= 1'b1;
         bit_idx <= '0;
      end else if (shift_o) begin
         if (bit_idx == LAST_IDX) begin
            busy    <= 1'b0;
            bit_idx <= '0;
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_cnt <= '0;
      end else if (convert_i && !load_o && ovr_cnt != OVR_MAX) begin
         ovr_cnt <= ovr_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/adc_ser_lane.sv
module adc_ser_lane #(
   parameter int unsigned HDR_W       = 4,
   parameter int unsigned CH_PER_LANE = 8,
   parameter int unsigned SAMPLE_W    = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_i,
   input  logic                            shift_i,
   input  logic                            bit_en_i,
   input  logic [HDR_W-1:0]                header_i,
   input  logic [CH_PER_LANE*SAMPLE_W-1:0] samples_i,
   output logic                            ser_o
);
   localparam int unsigned FRAME_LEN =
      adc_ser_pkg::lane_frame_bits(HDR_W, CH_PER_LANE, SAMPLE_W);

   logic [FRAME_LEN-1:0] frame_word;
   logic [FRAME_LEN-1:0] shreg;
   logic                 ser_q;

   always_comb begin
      frame_word = '0;
      frame_word[FRAME_LEN-1 -: HDR_W] = header_i;
      for (int c = 0; c < int'(CH_PER_LANE); c++) begin
         frame_word[FRAME_LEN-1-HDR_W-c*SAMPLE_W -: SAMPLE_W] =
            samples_i[c*SAMPLE_W +: SAMPLE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         ser_q <= 1'b0;
      end else begin
         if (bit_en_i) begin
            ser_q <= shift_i ? shreg[FRAME_LEN-1] : 1'b0;
         end
         if (load_i) begin
            shreg <= frame_word;
         end else if (shift_i) begin
            shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
         end
      end
   end

   assign ser_o = ser_q;
endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer #(
   parameter int unsigned NUM_CH    = 16,
   parameter int unsigned SAMPLE_W  = 12,
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned HDR_W     = 4,
   parameter int unsigned OVR_W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH*SAMPLE_W-1:0]   samples_i,
   input  logic                         convert_i,
   input  logic                         bit_en_i,
   input  logic [HDR_W-1:0]             header_i,
   output logic [NUM_LANES-1:0]         ser_o,
   output logic                         frame_start_o,
   output logic [OVR_W-1:0]             overrun_cnt_o
);
   localparam int unsigned CH_PER_LANE = NUM_CH / NUM_LANES;
   localparam int unsigned LANE_BITS   = CH_PER_LANE * SAMPLE_W;
   localparam int unsigned FRAME_LEN   =
      adc_ser_pkg::lane_frame_bits(HDR_W, CH_PER_LANE, SAMPLE_W);

   generate
      if (NUM_LANES == 0 || (NUM_CH % NUM_LANES) != 0) begin : g_bad_split
         $error("channel count must divide evenly over the lanes");
      end
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("frame must be at least two bits long");
      end
      if (HDR_W == 0 || SAMPLE_W == 0 || OVR_W == 0) begin : g_bad_width
         $error("header, sample and counter widths must be non-zero");
      end
   endgenerate

   logic load, shift, first, busy, last_bit;
   logic fs_q;

   adc_ser_ctrl #(
      .FRAME_LEN (FRAME_LEN),
      .OVR_W     (OVR_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .convert_i     (convert_i),
      .bit_en_i      (bit_en_i),
      .load_o        (load),
      .shift_o       (shift),
      .first_o       (first),
      .busy_o        (busy),
      .last_o        (last_bit),
      .overrun_cnt_o (overrun_cnt_o)
   );

   generate
      for (genvar s = 0; s < int'(NUM_LANES); s++) begin : g_lane
         adc_ser_lane #(
            .HDR_W       (HDR_W),
            .CH_PER_LANE (CH_PER_LANE),
            .SAMPLE_W    (SAMPLE_W)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .shift_i   (shift),
            .bit_en_i  (bit_en_i),
            .header_i  (header_i),
            .samples_i (samples_i[s*LANE_BITS +: LANE_BITS]),
            .ser_o     (ser_o[s])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q <= 1'b0;
      end else if (bit_en_i) begin
         fs_q <= first;
      end
   end

   assign frame_start_o = fs_q;
endmodule

// File: rtl/adc_ser_checker.sv
module adc_ser_checker #(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned OVR_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 convert_i,
   input logic                 bit_en_i,
   input logic [NUM_LANES-1:0] ser_o,
   input logic                 frame_start_o,
   input logic [OVR_W-1:0]     overrun_cnt_o,
   input logic                 busy,
   input logic                 last_bit
);
   localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en_i |=> ($stable(ser_o) && $stable(frame_start_o)));

   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start_o && bit_en_i) |=> !frame_start_o);

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en_i && !busy) |=> (ser_o == '0 && !frame_start_o));

   p_drop_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (convert_i && busy && !last_bit && overrun_cnt_o != OVR_MAX)
      |=> (overrun_cnt_o == $past(overrun_cnt_o) + 1'b1));

   p_ovr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (overrun_cnt_o == $past(overrun_cnt_o) ||
                overrun_cnt_o == $past(overrun_cnt_o) + 1'b1));

   p_gapless_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (convert_i && last_bit) |=> busy);
endmodule

bind adc_frame_serializer adc_ser_checker #(
   .NUM_LANES (NUM_LANES),
   .OVR_W     (OVR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .convert_i     (convert_i),
   .bit_en_i      (bit_en_i),
   .ser_o         (ser_o),
   .frame_start_o (frame_start_o),
   .overrun_cnt_o (overrun_cnt_o),
   .busy          (busy),
   .last_bit      (last_bit)
);

// File: tb/adc_frame_serializer_bench.sv
module adc_frame_serializer_bench;
   localparam int NCH = 16, SW = 12, NL = 2, HW = 4, OW = 8;
   localparam int CPL = NCH / NL;
   localparam int FL  = HW + CPL * SW;
   localparam int OVR_MAX = (1 << OW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH*SW-1:0] samples = '0;
   logic convert = 1'b0, bit_en = 1'b0;
   logic [HW-1:0] header = '0;
   logic [NL-1:0] ser;
   logic fs;
   logic [OW-1:0] ovr;

   int tests = 0, fails = 0, cycles = 0;
   string scen = "R1";

   always #5 clk = ~clk;

   adc_frame_serializer u_adc_frame_serializer (
      .clk(clk), .rst_n(rst_n), .samples_i(samples), .convert_i(convert),
      .bit_en_i(bit_en), .header_i(header), .ser_o(ser),
      .frame_start_o(fs), .overrun_cnt_o(ovr));

   // behavioural reference: one bit queue per lane
   bit m_q[NL][$];
   logic [NL-1:0] m_ser = '0;
   logic m_fs = 1'b0;
   int m_ovr = 0;
   int m_pos = -1;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NL; s++) m_q[s].delete();
         m_ser = '0; m_fs = 1'b0; m_ovr = 0; m_pos = -1;
      end else begin
         automatic bit busy_m = (m_q[0].size() != 0);
         automatic bit last_m = busy_m && bit_en && (m_q[0].size() == 1);
         automatic bit acc = convert && (!busy_m || last_m);
         if (convert && !acc && m_ovr != OVR_MAX) m_ovr++;
         if (bit_en) begin
            if (busy_m) begin
               m_pos = FL - m_q[0].size();
               m_fs = (m_pos == 0);
               for (int s = 0; s < NL; s++) m_ser[s] = m_q[s].pop_front();
            end else begin
               m_pos = -1; m_ser = '0; m_fs = 1'b0;
            end
         end
         if (acc) begin
            for (int s = 0; s < NL; s++) begin
               m_q[s].delete();
               for (int b = HW - 1; b >= 0; b--) m_q[s].push_back(header[b]);
               for (int c = s * CPL; c < (s + 1) * CPL; c++)
                  for (int b = SW - 1; b >= 0; b--) m_q[s].push_back(samples[c*SW + b]);
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s (%s) actual=%0d expected=%0d at cycle %0d", tag, scen, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      for (int s = 0; s < NL; s++)
         check(ser[s] === m_ser[s], (m_pos < 0) ? "R9" : (m_pos < HW) ? "R3" : "R4",
               int'(ser[s]), int'(m_ser[s]));
      check(fs === m_fs, "R2", int'(fs), int'(m_fs));
      check(int'(ovr) == m_ovr, "R7", int'(ovr), m_ovr);
      if (cycles > 150000) begin
         fails++;
         $display("FAIL R1 watchdog actual=%0d expected<=150000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic step(input bit cv, input bit be);
      @(negedge clk);
      convert = cv; bit_en = be;
   endtask

   task automatic new_data(input int seed);
      for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = SW'((c * 291 + seed * 77 + 5) ^ (seed << 3));
      header = HW'(seed + 9);
   endtask

   initial begin
      repeat (4) step(0, 1);
      rst_n = 1'b1;
      repeat (5) step(0, 1);

      // R5: sparse bit enables, strobe coinciding with an enable
      scen = "R5";
      new_data(1);
      step(1, 1);
      for (int i = 0; i < 320; i++) step(0, (i % 3) == 2);

      // R8: gapless back-to-back frames with fresh data every frame
      scen = "R8";
      for (int f = 0; f < 4; f++) begin
         new_data(f + 2);
         step(1, 1);
         if (f == 3) samples = '1;
         for (int i = 0; i < FL - 1; i++) step(0, 1);
      end
      repeat (6) step(0, 1);

      // R10: inputs move every cycle during a frame
      scen = "R10";
      new_data(20);
      step(1, 1);
      for (int i = 0; i < FL + 4; i++) begin
         samples = ~samples; header = ~header;
         step(0, 1);
      end

      // R6: irregular bit enables
      scen = "R6";
      new_data(30);
      step(1, 0);
      for (int i = 0; i < 260; i++) step(0, ((i * 7) % 5) < 2);

      // R7: dropped strobes mid-frame, then saturation with enables held low
      scen = "R7";
      new_data(40);
      step(1, 1);
      repeat (10) step(0, 1);
      step(1, 1);
      step(0, 1);
      step(1, 0);
      for (int i = 0; i < 300; i++) step(1, 0);
      for (int i = 0; i < FL + 5; i++) step(0, 1);
      step(1, 1);
      repeat (3) step(0, 1);

      // R1: reset in mid-frame returns everything to idle
      scen = "R1";
      rst_n = 1'b0;
      repeat (3) step(0, 1);
      rst_n = 1'b1;
      repeat (5) step(0, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule